// File: doc/BRIEF.md
# Byte-Wide Accumulator Core with Fetch-Execute Sequencer

This block is a compact 8-bit accumulator processor core. It fetches instruction bytes one at a time from an external synchronous memory whose read data arrives one clock after the address, and it executes a small set of operations. The set covers zeroing the accumulator, loading and subtracting an immediate byte, and moving the accumulator to and from a 16-bit absolute address. The architectural state is a program counter, one accumulator and a four-bit flag register.

A sequencer walks each instruction through opcode fetch, operand fetch and execute states. Each fetched byte costs one request cycle and one capture cycle. Absolute addresses arrive high byte first, so instructions differ in length. Some reserved opcode values act as page prefixes that pull in a second opcode byte. No prefixed operation belongs to the implemented set, so any prefix stops the core once its second byte has been fetched. An unknown opcode also stops the core, and it stays stopped until reset.

A one-cycle completion pulse marks the end of every executed instruction. It rises in the same cycle that the next opcode address is presented.

Top module: `acc8_core`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, the program counter equals the START_PC parameter (default 0xE000). The accumulator and all flags are 0, halted, retire and mem_we are low, and mem_addr presents the program counter.
- R2: The program counter advances by exactly one for each fetched byte and changes in no other way. Each fetched byte takes two cycles, because the read data is captured one cycle after the address. Every instruction starts with its opcode address on mem_addr.
- R3: Opcode 0x4F takes no operand. It clears the accumulator and leaves flags = 4'b0100, where the flag bits are [3]=N, [2]=Z, [1]=V and [0]=C. It completes 3 cycles after its opcode address is presented.
- R4: Opcode 0x86 copies the next byte into the accumulator. It sets N to bit 7 of the result and sets Z when the result is zero. It clears V and keeps C. It completes after 5 cycles.
- R5: Opcode 0x80 subtracts the next byte from the accumulator. N and Z follow the result. V is set on two's-complement overflow. C is set when an unsigned borrow occurs. It completes after 5 cycles.
- R6: Opcode 0xB6 reads the high address byte and then the low address byte. It then loads the accumulator from that address, with flags updated as in R4, and completes after 8 cycles.
- R7: Opcode 0xB7 reads the high address byte and then the low address byte. In the 6th cycle of the instruction it drives mem_we high for exactly one cycle, with mem_addr set to that address and mem_wdata set to the accumulator. N and Z follow the accumulator, V is cleared and C is kept. It completes after 7 cycles.
- R8: Bytes 0x18, 0x1A and 0xCD are prefixes. The byte after a prefix is fetched as a second opcode byte. No prefixed combination is implemented, so halted rises 4 cycles after the prefix address was presented. At that point the program counter points just past the second byte, and the accumulator and flags are unchanged.
- R9: Any other unlisted single opcode raises halted 2 cycles after its address was presented. The program counter then points just past that opcode, and the accumulator and flags are unchanged.
- R10: Once halted is high it stays high until reset. The program counter holds, mem_we stays low and retire stays low.
- R11: retire is a one-cycle pulse. It is visible in the cycle after an instruction's last state, which is also the cycle in which the next opcode address is presented. The accumulator and flags visible in that cycle already hold the instruction's results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 16 | Memory byte address |
| mem_rdata | input | 8 | Memory read data, valid one cycle after the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| acc | output | 8 | Accumulator |
| flags | output | 4 | Flags {N, Z, V, C} |
| pc | output | 16 | Program counter |
| retire | output | 1 | One-cycle instruction completion pulse |
| halted | output | 1 | Sticky stop indication |

## Verification
Every result is due a fixed number of clock edges after the opcode address appears: 3 for a clear, 5 for an immediate operation, 7 for a store (with the write strobe in edge 6) and 8 for an absolute load. A prefix halts after 4 edges and an unknown opcode after 2. For each instruction the bench derives this count from its own decoding of the program bytes. It then samples on every falling edge in between, expecting retire, halted and mem_we low until the due edge and checking the accumulator, flags and program counter exactly there. Because the next instruction's window opens on that same sample, a single extra or missing cycle in any instruction shows up as a retire or address mismatch.

// File: rtl/acc8_core_pkg.sv
package acc8_core_pkg;

    typedef enum logic [2:0] {
        ST_OP_REQ,
        ST_OP_CAP,
        ST_ARG_REQ,
        ST_ARG_CAP,
        ST_EXEC,
        ST_RD_CAP,
        ST_HALT
    } seq_e;

    typedef enum logic [2:0] {
        K_CLR,
        K_LD_IMM,
        K_SUB_IMM,
        K_LD_ABS,
        K_ST_ABS,
        K_BAD
    } kind_e;

    localparam int unsigned FLAG_N = 3;
    localparam int unsigned FLAG_Z = 2;
    localparam int unsigned FLAG_V = 1;
    localparam int unsigned FLAG_C = 0;

    localparam logic [7:0] OPC_CLR     = 8'h4F;
    localparam logic [7:0] OPC_LD_IMM  = 8'h86;
    localparam logic [7:0] OPC_SUB_IMM = 8'h80;
    localparam logic [7:0] OPC_LD_ABS  = 8'hB6;
    localparam logic [7:0] OPC_ST_ABS  = 8'hB7;

    localparam int unsigned N_PREFIX = 3;
    localparam logic [7:0] PREFIX_TAB [N_PREFIX] = '{8'h18, 8'h1A, 8'hCD};

endpackage

// File: rtl/acc8_core_decode.sv
module acc8_core_decode
    import acc8_core_pkg::*;
#(
    parameter int unsigned DATA_W   = 8,
    parameter int unsigned EXT_ARGS = 2,
    parameter int unsigned CNT_W    = 2
) (
    input  logic [DATA_W-1:0] opcode,
    input  logic              page_ext,
    output logic              is_prefix,
    output logic              legal,
    output kind_e             kind,
    output logic [CNT_W-1:0]  n_args
);

    logic [N_PREFIX-1:0] hit;

    generate
        for (genvar i = 0; i < N_PREFIX; i++) begin : g_prefix
            assign hit[i] = (opcode == DATA_W'(PREFIX_TAB[i]));
        end
    endgenerate

    assign is_prefix = |hit;

    always_comb begin
        kind   = K_BAD;
        legal  = 1'b0;
        n_args = '0;
        if (!page_ext) begin
            if (opcode == DATA_W'(OPC_CLR)) begin
                kind  = K_CLR;
                legal = 1'b1;
            end else if (opcode == DATA_W'(OPC_LD_IMM)) begin
                kind   = K_LD_IMM;
                legal  = 1'b1;
                n_args = CNT_W'(1);
            end else if (opcode == DATA_W'(OPC_SUB_IMM)) begin
                kind   = K_SUB_IMM;
                legal  = 1'b1;
                n_args = CNT_W'(1);
            end else if (opcode == DATA_W'(OPC_LD_ABS)) begin
                kind   = K_LD_ABS;
                legal  = 1'b1;
                n_args = CNT_W'(EXT_ARGS);
            end else if (opcode == DATA_W'(OPC_ST_ABS)) begin
                kind   = K_ST_ABS;
                legal  = 1'b1;
                n_args = CNT_W'(EXT_ARGS);
            end
        end
    end

endmodule

// File: rtl/acc8_core_alu.sv
module acc8_core_alu
    import acc8_core_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  kind_e             kind,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd,
    input  logic [3:0]        flags_in,
    output logic [DATA_W-1:0] acc_out,
    output logic [3:0]        flags_out
);

    logic [DATA_W:0] diff;

    assign diff = {1'b0, acc_in} - {1'b0, opnd};

    always_comb begin
        acc_out   = acc_in;
        flags_out = flags_in;
        unique case (kind)
            K_CLR: begin
                acc_out   = '0;
                flags_out = '0;
                flags_out[FLAG_Z] = 1'b1;
            end
            K_LD_IMM, K_LD_ABS: begin
                acc_out = opnd;
                flags_out[FLAG_N] = opnd[DATA_W-1];
                flags_out[FLAG_Z] = (opnd == '0);
                flags_out[FLAG_V] = 1'b0;
            end
            K_SUB_IMM: begin
                acc_out = diff[DATA_W-1:0];
                flags_out[FLAG_N] = diff[DATA_W-1];
                flags_out[FLAG_Z] = (diff[DATA_W-1:0] == '0);
                flags_out[FLAG_V] = (acc_in[DATA_W-1] ^ opnd[DATA_W-1])
                                  & (acc_in[DATA_W-1] ^ diff[DATA_W-1]);
                flags_out[FLAG_C] = diff[DATA_W];
            end
            K_ST_ABS: begin
                flags_out[FLAG_N] = acc_in[DATA_W-1];
                flags_out[FLAG_Z] = (acc_in == '0);
                flags_out[FLAG_V] = 1'b0;
            end
            default: begin
                acc_out   = acc_in;
                flags_out = flags_in;
            end
        endcase
    end

endmodule

// File: rtl/acc8_core.sv
module acc8_core
    import acc8_core_pkg::*;
#(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned DATA_W   = 8,
    parameter logic [15:0] START_PC = 16'hE000
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    output logic [DATA_W-1:0] acc,
    output logic [3:0]        flags,
    output logic [ADDR_W-1:0] pc,
    output logic              retire,
    output logic              halted
);

    localparam int unsigned EXT_ARGS = ADDR_W / DATA_W;
    localparam int unsigned CNT_W    = $clog2(EXT_ARGS + 1);

    typedef struct packed {
        seq_e              st;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] a;
        logic [3:0]        f;
        kind_e             kind;
        logic              pre;
        logic [CNT_W-1:0]  left;
        logic [ADDR_W-1:0] arg;
        logic              retire;
    } regs_t;

    regs_t q, d;

    logic              dec_prefix;
    logic              dec_legal;
    kind_e             dec_kind;
    logic [CNT_W-1:0]  dec_nargs;
    logic [DATA_W-1:0] alu_opnd;
    logic [DATA_W-1:0] alu_acc;
    logic [3:0]        alu_flags;

    acc8_core_decode #(
        .DATA_W   (DATA_W),
        .EXT_ARGS (EXT_ARGS),
        .CNT_W    (CNT_W)
    ) u_decode (
        .opcode    (mem_rdata),
        .page_ext  (q.pre),
        .is_prefix (dec_prefix),
        .legal     (dec_legal),
        .kind      (dec_kind),
        .n_args    (dec_nargs)
    );

    assign alu_opnd = (q.st == ST_RD_CAP) ? mem_rdata : q.arg[DATA_W-1:0];

    acc8_core_alu #(
        .DATA_W (DATA_W)
    ) u_alu (
        .kind      (q.kind),
        .acc_in    (q.a),
        .opnd      (alu_opnd),
        .flags_in  (q.f),
        .acc_out   (alu_acc),
        .flags_out (alu_flags)
    );

    always_comb begin
        d         = q;
        d.retire  = 1'b0;
        mem_addr  = q.pc;
        mem_wdata = q.a;
        mem_we    = 1'b0;
        unique case (q.st)
            ST_OP_REQ: begin
                d.pc = q.pc + ADDR_W'(1);
                d.st = ST_OP_CAP;
            end
            ST_OP_CAP: begin
                if (!q.pre && dec_prefix) begin
                    d.pre = 1'b1;
                    d.st  = ST_OP_REQ;
                end else if (!dec_legal) begin
                    d.st = ST_HALT;
                end else begin
                    d.pre  = 1'b0;
                    d.kind = dec_kind;
                    d.left = dec_nargs;
                    d.arg  = '0;
                    d.st   = (dec_nargs == '0) ? ST_EXEC : ST_ARG_REQ;
                end
            end
            ST_ARG_REQ: begin
                d.pc = q.pc + ADDR_W'(1);
                d.st = ST_ARG_CAP;
            end
            ST_ARG_CAP: begin
                d.arg  = {q.arg[ADDR_W-DATA_W-1:0], mem_rdata};
                d.left = q.left - CNT_W'(1);
                d.st   = (q.left == CNT_W'(1)) ? ST_EXEC : ST_ARG_REQ;
            end
            ST_EXEC: begin
                if (q.kind == K_LD_ABS) begin
                    mem_addr = q.arg;
                    d.st     = ST_RD_CAP;
                end else begin
                    if (q.kind == K_ST_ABS) begin
                        mem_addr = q.arg;
                        mem_we   = 1'b1;
                    end
                    d.a      = alu_acc;
                    d.f      = alu_flags;
                    d.retire = 1'b1;
                    d.st     = ST_OP_REQ;
                end
            end
            ST_RD_CAP: begin
                d.a      = alu_acc;
                d.f      = alu_flags;
                d.retire = 1'b1;
                d.st     = ST_OP_REQ;
            end
            default: begin
                d.st = ST_HALT;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st     <= ST_OP_REQ;
            q.pc     <= ADDR_W'(START_PC);
            q.a      <= '0;
            q.f      <= '0;
            q.kind   <= K_BAD;
            q.pre    <= 1'b0;
            q.left   <= '0;
            q.arg    <= '0;
            q.retire <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign acc    = q.a;
    assign flags  = q.f;
    assign pc     = q.pc;
    assign retire = q.retire;
    assign halted = (q.st == ST_HALT);

endmodule

// File: rtl/acc8_core_chk.sv
module acc8_core_chk #(
    parameter int unsigned ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] pc,
    input logic              mem_we,
    input logic              retire,
    input logic              halted
);

    // R10: stop is sticky
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    // R10: program counter frozen while stopped
    a_r10_pc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> $stable(pc));

    // R10: no writes while stopped
    a_r10_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !mem_we);

    // R2: program counter only ever steps by one
    a_r2_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pc != $past(pc)) |-> (pc == $past(pc) + ADDR_W'(1)));

    // R11: completion is a single-cycle pulse
    a_r11_retire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        retire |=> !retire);

    // R11: no completion reported while stopped
    a_r11_retire_live: assert property (@(posedge clk) disable iff (!rst_n)
        retire |-> !halted);

    // R7: write strobe lasts one cycle
    a_r7_write_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

endmodule

bind acc8_core acc8_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pc     (pc),
    .mem_we (mem_we),
    .retire (retire),
    .halted (halted)
);

// File: tb/acc8_core_test.sv
module acc8_core_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata = 8'h00;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  acc;
    logic [3:0]  flags;
    logic [15:0] pc;
    logic        retire;
    logic        halted;

    logic        ld_we = 1'b0;
    logic [15:0] ld_a = '0;
    logic [7:0]  ld_d = '0;

    logic [7:0]  mem [0:65535];
    logic [7:0]  sh  [0:65535];

    logic [15:0] pc_m;
    logic [7:0]  a_m;
    logic [3:0]  f_m;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc8_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .acc       (acc),
        .flags     (flags),
        .pc        (pc),
        .retire    (retire),
        .halted    (halted)
    );

    always @(posedge clk) begin
        mem_rdata <= mem[mem_addr];
        if (ld_we) mem[ld_a] <= ld_d;
        else if (mem_we) mem[mem_addr] <= mem_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic put(input logic [15:0] a, input logic [7:0] d);
        ld_a  = a;
        ld_d  = d;
        ld_we = 1'b1;
        sh[a] = d;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic check_reset();
        pc_m = 16'hE000;
        a_m  = 8'h00;
        f_m  = 4'h0;
        chk(pc === 16'hE000, "R1", "pc", pc, 16'hE000);
        chk(acc === 8'h00, "R1", "acc", acc, 0);
        chk(flags === 4'h0, "R1", "flags", flags, 0);
        chk(halted === 1'b0 && retire === 1'b0 && mem_we === 1'b0, "R1", "controls",
            {halted, retire, mem_we}, 0);
        chk(mem_addr === 16'hE000, "R1", "mem_addr", mem_addr, 16'hE000);
    endtask

    task automatic run_one(output bit halt_seen);
        logic [7:0]  op, x;
        logic [15:0] ea, pc_n;
        logic [7:0]  a_n;
        logic [3:0]  f_n;
        logic [8:0]  diff;
        int          len;
        bit          is_halt, is_st, due_we;
        string       req;
        op      = sh[pc_m];
        x       = sh[pc_m + 16'd1];
        ea      = {sh[pc_m + 16'd1], sh[pc_m + 16'd2]};
        a_n     = a_m;
        f_n     = f_m;
        is_halt = 1'b0;
        is_st   = 1'b0;
        chk(mem_addr === pc_m, "R2", "opcode address", mem_addr, pc_m);
        case (op)
            8'h4F: begin
                len = 3; req = "R3"; a_n = 8'h00; f_n = 4'b0100; pc_n = pc_m + 16'd1;
            end
            8'h86: begin
                len = 5; req = "R4"; a_n = x;
                f_n = {x[7], x == 8'h00, 1'b0, f_m[0]}; pc_n = pc_m + 16'd2;
            end
            8'h80: begin
                len = 5; req = "R5"; diff = {1'b0, a_m} - {1'b0, x}; a_n = diff[7:0];
                f_n = {a_n[7], a_n == 8'h00, (a_m[7] ^ x[7]) & (a_m[7] ^ a_n[7]), diff[8]};
                pc_n = pc_m + 16'd2;
            end
            8'hB6: begin
                len = 8; req = "R6"; a_n = sh[ea];
                f_n = {a_n[7], a_n == 8'h00, 1'b0, f_m[0]}; pc_n = pc_m + 16'd3;
            end
            8'hB7: begin
                len = 7; req = "R7"; is_st = 1'b1;
                f_n = {a_m[7], a_m == 8'h00, 1'b0, f_m[0]}; pc_n = pc_m + 16'd3;
            end
            8'h18, 8'h1A, 8'hCD: begin
                len = 4; req = "R8"; is_halt = 1'b1; pc_n = pc_m + 16'd2;
            end
            default: begin
                len = 2; req = "R9"; is_halt = 1'b1; pc_n = pc_m + 16'd1;
            end
        endcase
        for (int c = 1; c <= len; c++) begin
            @(negedge clk);
            due_we = is_st && (c == 6);
            chk(mem_we === due_we, "R7", "write strobe", mem_we, due_we);
            if (due_we) begin
                chk(mem_addr === ea, "R7", "write address", mem_addr, ea);
                chk(mem_wdata === a_m, "R7", "write data", mem_wdata, a_m);
            end
            chk(retire === (!is_halt && c == len), "R11", "retire", retire,
                (!is_halt && c == len));
            chk(halted === (is_halt && c == len), req, "halted", halted,
                (is_halt && c == len));
        end
        chk(acc === a_n, req, "acc", acc, a_n);
        chk(flags === f_n, req, "flags", flags, f_n);
        chk(pc === pc_n, req, "pc", pc, pc_n);
        if (is_st) sh[ea] = a_m;
        a_m       = a_n;
        f_m       = f_n;
        pc_m      = pc_n;
        halt_seen = is_halt;
    endtask

    task automatic run_until_halt();
        bit h;
        h = 1'b0;
        for (int n = 0; n < 64 && !h; n++) run_one(h);
        chk(h, "R9", "program reached stop", h, 1);
    endtask

    task automatic hold_check();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            chk(halted === 1'b1, "R10", "halted held", halted, 1);
            chk(pc === pc_m, "R10", "pc held", pc, pc_m);
            chk(mem_we === 1'b0 && retire === 1'b0, "R10", "quiet", {mem_we, retire}, 0);
        end
    endtask

    task automatic load_prog(input logic [15:0] base, input logic [7:0] b [$]);
        foreach (b[i]) put(base + 16'(i), b[i]);
    endtask

    initial begin
        logic [7:0] prog_a [$];
        logic [7:0] prog_b [$];
        prog_a = '{8'h4F, 8'h86, 8'h7F, 8'h80, 8'h80, 8'h86, 8'h00,
                   8'h86, 8'h05, 8'h80, 8'h05, 8'h86, 8'hA5,
                   8'hB7, 8'h20, 8'h31, 8'h4F, 8'hB6, 8'h20, 8'h31,
                   8'hB6, 8'h12, 8'h34, 8'h80, 8'h3D, 8'h18, 8'h86};
        prog_b = '{8'h86, 8'h10, 8'h01};
        @(negedge clk);
        put(16'h1234, 8'h3C);
        put(16'h3412, 8'hEE);
        put(16'h2031, 8'h00);
        load_prog(16'hE000, prog_a);
        check_reset();
        rst_n = 1'b1;
        #1;
        check_reset();
        run_until_halt();
        hold_check();

        @(negedge clk);
        rst_n = 1'b0;
        load_prog(16'hE000, prog_b);
        check_reset();
        rst_n = 1'b1;
        #1;
        run_until_halt();
        hold_check();

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL R11 watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule